// File: doc/BRIEF.md
# Block Lifecycle Sequencer for a Frame-Partitioned Grid Core

This controller manages atomic instruction blocks in a grid-style execution core. The core's reservation-station frames are grouped into block slots: 128 frames in groups of 4, which gives 32 slots. The sequencer decides which slot the next fetched block is written into. It records when the execution array reports a block finished, and it retires blocks one at a time in program order. A block's results become visible all together, in the cycle its commit pulse appears. The fetch unit, the predictor and the execution array sit around the block, and they exchange only slot indices and pulses with it.

A two-bit mode input selects the allocation policy:

- **Speculative mode** runs a single thread. That thread may hold up to a programmable number of blocks in flight.
- **Multithread mode** splits the slots into equal contiguous ranges, one per thread. The lowest-numbered ready thread wins both fetch and commit.
- **Streaming mode** keeps a finished block mapped and re-runs it in place until its iteration count runs out. It then releases the slot.

A misprediction discards the younger blocks of the affected thread and holds that thread's fetch for a fixed penalty. An interrupt is taken only between blocks.

Top module: `block_seq`

## Requirements
- R1: Reset behaviour. After reset, `commit_vld`, `revive_vld` and `irq_taken` are low and no block is in flight. In speculative mode the first fetch request targets slot 0 for thread 0.
- R2: Speculative mode (mode 0, and also mode 3). `fetch_req` is high while the number of blocks in flight is below `spec_depth`. A depth of 0 counts as 1, and a depth above 32 counts as 32. Granted slots follow each other in ascending order and wrap at 32.
- R3: A block commits only when it is the oldest block of its thread. `commit_vld` rises one cycle after that block's `done_vld`. A younger block that finishes first waits until every older block has committed.
- R4: A flush on `flush_slot` behaves as follows. That block stays in flight. Every younger block of the same thread is discarded. The thread's next fetch targets the slot after `flush_slot`.
- R5: After the flush cycle, the flushed thread raises no fetch request for exactly 10 cycles.
- R6: Multithread mode (mode 1) runs 2^`thr_sel` threads. Thread t owns slots t*P to t*P+P-1, where P = 32 >> `thr_sel`, and it may hold up to P blocks in flight. `fetch_thr` and `fetch_slot` always name a slot inside the owning thread's range.
- R7: In multithread mode, fetch goes to the lowest-numbered thread that still has room. Commit goes to the lowest-numbered thread whose oldest block is done.
- R8: Streaming mode (mode 2) loads an iteration count N with the grant. The block then runs max(N,1) times: each of the first N-1 completions raises `revive_vld` for its slot, and the last completion commits. In the other modes the count is ignored and `revive_vld` stays low.
- R9: A pulse on `irq_req` stops fetch from the next cycle on. The interrupt is taken on the next commit, or at once if nothing is in flight. `irq_taken` pulses for one cycle, and every remaining block is discarded, so a later completion on one of those blocks never commits.
- R10: No commit or revive happens in a cycle where `flush_vld` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | 0 speculative, 1 multithread, 2 streaming, 3 as 0 |
| thr_sel | input | 2 | log2 of thread count in multithread mode |
| spec_depth | input | 6 | Blocks allowed in flight in speculative and streaming modes |
| fetch_req | output | 1 | A slot is free for the next block |
| fetch_thr | output | 3 | Thread that the fetch is for |
| fetch_slot | output | 5 | Slot that receives the fetched block |
| fetch_gnt | input | 1 | The fetch unit accepts the request this cycle |
| fetch_iters | input | 8 | Iteration count loaded with the granted block |
| done_vld | input | 1 | The execution array reports a block finished |
| done_slot | input | 5 | Slot of the finished block |
| flush_vld | input | 1 | Misprediction on a block |
| flush_slot | input | 5 | Slot of the mispredicted block |
| commit_vld | output | 1 | Atomic commit of one block |
| commit_slot | output | 5 | Slot being committed and released |
| revive_vld | output | 1 | Block is re-executed in place |
| revive_slot | output | 5 | Slot being re-executed |
| irq_req | input | 1 | Interrupt request pulse |
| irq_taken | output | 1 | Interrupt taken at a block boundary |

## Verification
The assertions assume the following about the inputs:
- `mode` and `thr_sel` change only while reset is held.
- `done_vld` and `flush_vld` name only slots that hold a block in flight.
- `irq_req` is a single pulse that does not coincide with a flush or with a pending interrupt.

The stimulus holds to these conditions by construction. Every test begins with a reset into its mode. Directed completions and flushes are issued only on slots the bench has just seen granted. The random phase picks completion slots only from its own model of each thread's in-flight window, and it never drives a flush or an interrupt.

// File: rtl/block_seq.sv
module block_seq #(
  parameter int NSLOT = 32,
  parameter int MAXT = 8,
  parameter int IW = 8,
  parameter int MISS_PEN = 10,
  parameter int SW = $clog2(NSLOT),
  parameter int TW = $clog2(MAXT),
  parameter int LW = $clog2($clog2(MAXT) + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    mode,
  input  logic [LW-1:0] thr_sel,
  input  logic [SW:0]   spec_depth,
  output logic          fetch_req,
  output logic [TW-1:0] fetch_thr,
  output logic [SW-1:0] fetch_slot,
  input  logic          fetch_gnt,
  input  logic [IW-1:0] fetch_iters,
  input  logic          done_vld,
  input  logic [SW-1:0] done_slot,
  input  logic          flush_vld,
  input  logic [SW-1:0] flush_slot,
  output logic          commit_vld,
  output logic [SW-1:0] commit_slot,
  output logic          revive_vld,
  output logic [SW-1:0] revive_slot,
  input  logic          irq_req,
  output logic          irq_taken
);
  localparam int PW = $clog2(MISS_PEN + 1);

  logic [NSLOT-1:0] done_q;
  logic [IW-1:0]    iter_q [NSLOT];
  logic [SW-1:0]    head_q [MAXT];
  logic [SW:0]      cnt_q  [MAXT];
  logic [PW-1:0]    stall_q[MAXT];
  logic             pend_q, taken_q;

  logic          mt, strm, again, take, fire, empty, fsel, csel;
  logic [LW-1:0] lg;
  logic [SW-1:0] pmask, fslot, cslot, age;
  logic [SW:0]   dep, cap;
  logic [TW-1:0] fthr, cthr, lthr;

  assign mt    = mode == 2'd1;
  assign strm  = mode == 2'd2;
  assign lg    = !mt ? '0 : (thr_sel > LW'(TW) ? LW'(TW) : thr_sel);
  assign pmask = SW'((NSLOT >> lg) - 1);
  assign dep   = spec_depth == '0 ? (SW+1)'(1) :
                 (spec_depth > (SW+1)'(NSLOT) ? (SW+1)'(NSLOT) : spec_depth);
  assign cap   = mt ? (SW+1)'(NSLOT >> lg) : dep;

  always_comb begin
    fsel = 1'b0; fthr = '0; fslot = '0;
    for (int t = MAXT-1; t >= 0; t--)
      if ((t >> lg) == 0 && cnt_q[t] < cap && stall_q[t] == '0) begin
        fsel  = 1'b1;
        fthr  = TW'(t);
        fslot = (SW'(t) << (SW - int'(lg))) | ((head_q[t] + cnt_q[t][SW-1:0]) & pmask);
      end
  end

  always_comb begin
    csel = 1'b0; cthr = '0; cslot = '0; empty = 1'b1;
    for (int t = MAXT-1; t >= 0; t--) begin
      if (cnt_q[t] != '0) empty = 1'b0;
      if ((t >> lg) == 0 && cnt_q[t] != '0 &&
          done_q[(SW'(t) << (SW - int'(lg))) | head_q[t]]) begin
        csel  = 1'b1;
        cthr  = TW'(t);
        cslot = (SW'(t) << (SW - int'(lg))) | head_q[t];
      end
    end
  end

  assign again       = strm && iter_q[cslot] > IW'(1);
  assign fetch_req   = fsel && !pend_q && !flush_vld;
  assign fetch_thr   = fthr;
  assign fetch_slot  = fslot;
  assign commit_vld  = csel && !flush_vld && !again;
  assign commit_slot = cslot;
  assign revive_vld  = csel && !flush_vld && again;
  assign revive_slot = cslot;
  assign irq_taken   = taken_q;
  assign fire        = fetch_req && fetch_gnt;
  assign take        = pend_q && (commit_vld || empty);
  assign lthr        = mt ? TW'(flush_slot >> (SW - int'(lg))) : '0;
  assign age         = ((flush_slot & pmask) - head_q[lthr]) & pmask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q  <= '0;
      pend_q  <= 1'b0;
      taken_q <= 1'b0;
      for (int s = 0; s < NSLOT; s++) iter_q[s] <= '0;
      for (int t = 0; t < MAXT; t++) begin
        head_q[t]  <= '0;
        cnt_q[t]   <= '0;
        stall_q[t] <= '0;
      end
    end else begin
      pend_q  <= take ? 1'b0 : (pend_q | irq_req);
      taken_q <= take;
      for (int t = 0; t < MAXT; t++) begin
        if (take)
          cnt_q[t] <= '0;
        else if (flush_vld && lthr == TW'(t))
          cnt_q[t] <= {1'b0, age} + (SW+1)'(1);
        else
          cnt_q[t] <= cnt_q[t] + (SW+1)'(fire && fthr == TW'(t))
                               - (SW+1)'(commit_vld && cthr == TW'(t));
        if (commit_vld && cthr == TW'(t))
          head_q[t] <= (head_q[t] + SW'(1)) & pmask;
        if (flush_vld && lthr == TW'(t))
          stall_q[t] <= PW'(MISS_PEN);
        else if (stall_q[t] != '0)
          stall_q[t] <= stall_q[t] - PW'(1);
      end
      if (fire) begin
        done_q[fslot] <= 1'b0;
        iter_q[fslot] <= fetch_iters;
      end
      if (revive_vld) begin
        done_q[cslot] <= 1'b0;
        iter_q[cslot] <= iter_q[cslot] - IW'(1);
      end
      if (done_vld) done_q[done_slot] <= 1'b1;
    end
  end
endmodule

// File: rtl/block_seq_chk.sv
module block_seq_chk #(
  parameter int NSLOT = 32,
  parameter int MAXT = 8,
  parameter int SW = $clog2(NSLOT),
  parameter int TW = $clog2(MAXT),
  parameter int LW = $clog2($clog2(MAXT) + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    mode,
  input logic [LW-1:0] thr_sel,
  input logic          fetch_req,
  input logic [TW-1:0] fetch_thr,
  input logic [SW-1:0] fetch_slot,
  input logic          flush_vld,
  input logic          commit_vld,
  input logic          revive_vld,
  input logic          irq_req,
  input logic          irq_taken
);
  // R10
  flush_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_vld |-> !commit_vld && !revive_vld);

  // R5
  flush_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_vld && mode != 2'd1) |=> !fetch_req);

  // R6
  thr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd1 && fetch_req) |-> ((fetch_slot >> (SW - int'(thr_sel))) == SW'(fetch_thr)));

  // R8
  no_revive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 2'd2) |-> !revive_vld);

  // R9
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |=> !fetch_req);

  // R9
  irq_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_taken |=> !commit_vld);
endmodule

bind block_seq block_seq_chk #(.NSLOT(NSLOT), .MAXT(MAXT)) chk_i (.*);

// File: tb/tb_block_seq.sv
module tb_block_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] mode = '0;
  logic [1:0] thr_sel = '0;
  logic [5:0] spec_depth = '0;
  logic fetch_gnt = 1'b0, done_vld = 1'b0, flush_vld = 1'b0, irq_req = 1'b0;
  logic [7:0] fetch_iters = '0;
  logic [4:0] done_slot = '0, flush_slot = '0;
  logic fetch_req, commit_vld, revive_vld, irq_taken;
  logic [2:0] fetch_thr;
  logic [4:0] fetch_slot, commit_slot, revive_slot;

  int total = 0, bad = 0;
  int m_head[4], m_cnt[4];
  bit m_done[32];

  always #4 clk = ~clk;

  block_seq dut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .thr_sel(thr_sel), .spec_depth(spec_depth),
    .fetch_req(fetch_req), .fetch_thr(fetch_thr), .fetch_slot(fetch_slot),
    .fetch_gnt(fetch_gnt), .fetch_iters(fetch_iters),
    .done_vld(done_vld), .done_slot(done_slot),
    .flush_vld(flush_vld), .flush_slot(flush_slot),
    .commit_vld(commit_vld), .commit_slot(commit_slot),
    .revive_vld(revive_vld), .revive_slot(revive_slot),
    .irq_req(irq_req), .irq_taken(irq_taken));

  task automatic chk(string r, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", r, act, exp);
    end
  endtask

  task automatic tick;
    @(negedge clk);
  endtask

  task automatic do_reset(input logic [1:0] m, input logic [1:0] ts, input logic [5:0] d);
    rst_n = 1'b0; mode = m; thr_sel = ts; spec_depth = d;
    fetch_gnt = 0; done_vld = 0; flush_vld = 0; irq_req = 0;
    tick; tick;
    rst_n = 1'b1;
  endtask

  function automatic int exp_fetch();
    for (int t = 0; t < 4; t++)
      if (m_cnt[t] < 8) return 1000 + t * 100 + t * 8 + ((m_head[t] + m_cnt[t]) % 8);
    return 0;
  endfunction

  function automatic int exp_commit();
    for (int t = 0; t < 4; t++)
      if (m_cnt[t] > 0 && m_done[t * 8 + m_head[t]]) return 100 + t * 8 + m_head[t];
    return 0;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL R1 watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    void'($urandom(32'd2024));
    do_reset(2'd0, 2'd0, 6'd3);
    #1;
    chk("R1 fetch_req", fetch_req, 1);
    chk("R1 fetch_slot", fetch_slot, 0);
    chk("R1 quiet", {commit_vld, revive_vld, irq_taken}, 0);

    fetch_iters = 8'd5; fetch_gnt = 1;
    for (int i = 0; i < 3; i++) begin
      chk("R2 slot order", fetch_slot, i);
      tick; #1;
    end
    chk("R2 depth limit", fetch_req, 0);
    fetch_gnt = 0;

    done_vld = 1; done_slot = 5'd1; tick; done_vld = 0; #1;
    chk("R3 younger waits", commit_vld, 0);
    done_vld = 1; done_slot = 5'd0; tick; done_vld = 0; #1;
    chk("R3 oldest commits", {commit_vld, commit_slot}, 32 + 0);
    chk("R8 no revive in speculative mode", revive_vld, 0);
    tick; #1;
    chk("R3 next in order", {commit_vld, commit_slot}, 32 + 1);
    tick; #1;
    chk("R3 drained", commit_vld, 0);
    chk("R2 reopen", {fetch_req, fetch_slot}, 32 + 3);

    fetch_gnt = 1; tick; #1;
    chk("R2 next slot", fetch_slot, 4);
    tick; fetch_gnt = 0; #1;
    chk("R2 full again", fetch_req, 0);

    done_vld = 1; done_slot = 5'd2; tick; done_vld = 0;
    flush_vld = 1; flush_slot = 5'd2; #1;
    chk("R10 no commit during flush", commit_vld, 0);
    tick; flush_vld = 0; #1;
    chk("R4 flushed block kept", {commit_vld, commit_slot}, 32 + 2);
    n = 0;
    while (!fetch_req && n < 40) begin n++; tick; #1; end
    chk("R5 penalty cycles", n, 10);
    chk("R4 refetch after flushed block", fetch_slot, 3);

    fetch_gnt = 1; tick; tick; fetch_gnt = 0; irq_req = 1; #1;
    tick; irq_req = 0; #1;
    chk("R9 fetch blocked", fetch_req, 0);
    done_vld = 1; done_slot = 5'd3; tick; done_vld = 0; #1;
    chk("R9 oldest commits", {commit_vld, commit_slot}, 32 + 3);
    tick; #1;
    chk("R9 taken pulse", irq_taken, 1);
    done_vld = 1; done_slot = 5'd4; tick; done_vld = 0; #1;
    chk("R9 single pulse", irq_taken, 0);
    chk("R9 discarded block no commit", commit_vld, 0);
    chk("R9 fetch resumes", {fetch_req, fetch_slot}, 32 + 4);

    spec_depth = 6'd0; fetch_gnt = 1; #1;
    chk("R2 depth zero allows one", fetch_req, 1);
    tick; fetch_gnt = 0; #1;
    chk("R2 depth zero clamps to one", fetch_req, 0);

    do_reset(2'd2, 2'd0, 6'd1);
    fetch_iters = 8'd3; fetch_gnt = 1; #1; tick; fetch_gnt = 0; #1;
    for (int k = 0; k < 3; k++) begin
      done_vld = 1; done_slot = 5'd0; tick; done_vld = 0; #1;
      chk("R8 revive", revive_vld, (k < 2) ? 1 : 0);
      chk("R8 commit on last run", commit_vld, (k == 2) ? 1 : 0);
      if (k < 2) chk("R8 revive slot", revive_slot, 0);
      tick; #1;
      chk("R8 idle between runs", {commit_vld, revive_vld}, 0);
    end
    fetch_iters = 8'd0; fetch_gnt = 1; #1;
    chk("R8 next slot", fetch_slot, 1);
    tick; fetch_gnt = 0;
    done_vld = 1; done_slot = 5'd1; tick; done_vld = 0; #1;
    chk("R8 zero count runs once", {commit_vld, revive_vld, commit_slot}, 64 + 1);

    do_reset(2'd1, 2'd1, 6'd1);
    fetch_gnt = 1; #1;
    for (int i = 0; i < 16; i++) begin
      chk("R6 thread0 range", fetch_thr * 100 + fetch_slot, i);
      tick; #1;
    end
    chk("R7 thread1 after thread0 full", fetch_thr * 100 + fetch_slot, 100 + 16);
    fetch_gnt = 0;

    do_reset(2'd1, 2'd2, 6'd1);
    for (int t = 0; t < 4; t++) begin m_head[t] = 0; m_cnt[t] = 0; end
    for (int s = 0; s < 32; s++) m_done[s] = 0;
    for (int cyc = 0; cyc < 600; cyc++) begin
      int t, a, ef, ec;
      logic g, dv;
      logic [4:0] ds;
      g = ($urandom % 2) == 1;
      dv = 0; ds = '0;
      t = $urandom % 4;
      if (m_cnt[t] > 0 && ($urandom % 4) != 0) begin
        a = $urandom % m_cnt[t];
        ds = 5'(t * 8 + ((m_head[t] + a) % 8));
        dv = 1;
      end
      fetch_gnt = g; done_vld = dv; done_slot = ds;
      #1;
      ef = exp_fetch();
      ec = exp_commit();
      chk("R7 fetch priority", fetch_req ? 1000 + fetch_thr * 100 + fetch_slot : 0, ef);
      chk("R7 commit priority", commit_vld ? 100 + commit_slot : 0, ec);
      if (g && ef != 0) begin
        m_done[ef % 100] = 0;
        m_cnt[(ef / 100) % 10]++;
      end
      if (ec != 0) begin
        m_head[(ec - 100) / 8] = (m_head[(ec - 100) / 8] + 1) % 8;
        m_cnt[(ec - 100) / 8]--;
      end
      if (dv) m_done[ds] = 1;
      tick;
    end
    fetch_gnt = 0; done_vld = 0;

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule